// File: doc/BRIEF.md
# Filtered I2C Target Controller

This block is a byte-wide I2C target (slave) that runs from a system clock much faster than the bus. It synchronises SCL and SDA, passes both through an optional glitch filter, finds START and STOP conditions, compares the received 7-bit address with a programmed one, and then moves data bytes in either direction through a single data register. It acknowledges bytes by pulling SDA low through an open-drain enable and records the master's acknowledge when it transmits.

Software sees five 8-bit registers through a simple select/write-enable/read-data port. The registers hold configuration, status flags, the data byte, the own address, and an idle-bus timeout. The timeout returns the target to idle when SCL stops moving during a transfer. There is no clock stretching, so the next byte to transmit must be in the data register before the acknowledge clock of the previous byte ends.

Top module: `i2c_tgt`

## Requirements
- R1: After reset every register reads 0x00 and `sda_oe` is 0.
- R2: Control bits 3:2 select the input filter: 00 = synchroniser only, 01 = a new level is accepted after 2 stable system clocks, 10 or 11 = after 4 stable clocks. An SCL low pulse shorter than the selected length during a bit's high phase does not disturb the address byte, and a longer one corrupts it.
- R3: A START (SDA falls while SCL is high) sets busy (status bit 5), and a STOP (SDA rises while SCL is high) clears it. Busy never rises in the same cycle as addressed is set.
- R4: When the 7 address bits equal own-address register bits 7:1, the target pulls SDA low during the 9th clock, sets addressed (status bit 6) and the match flag (status bit 1), and latches R/W into status bit 2. On a mismatch it leaves SDA released and sets none of these.
- R5: In receive mode the received byte appears in the data register (offset 2). The target acknowledges when status bit 3 is 0 and leaves SDA released on the 9th clock when it is 1.
- R6: In transmit mode the data register is driven MSB first, SDA is released on the 9th clock, and the master's acknowledge bit is stored in status bit 0. A NACK ends transmission (status bit 4, transmit mode, reads 0). The drive enable rises only while SCL is low.
- R7: Status bit 7 sets after the 9th clock of every address-matched byte. It stays set until software writes status with bit 7 = 0.
- R8: Addressed clears on STOP or on a repeated START, and it is never set while busy is clear.
- R9: With timeout bit 7 set, the target counts system clocks while busy and restarts the count on every SCL edge. After (bits 5:0 + 1) × 64 clocks it sets timeout bit 6 and clears busy. Writing bit 6 as 0 clears the flag.
- R10: With control bit 1 (enable) at 0, the target never drives SDA and busy stays 0.
- R11: Register offsets: control 0, status 1, data 2, own address 3, timeout 4. Control reads back only bits 3:1 and own address only bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| reg_sel | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |

## Verification
The bound checker watches invariants on every cycle. The drive enable stays quiet while the block is disabled, addressed implies busy, a new busy period starts unaddressed, the completion flag is sticky until software clears it, the drive enable only rises with SCL low, and a timeout always leaves the bus idle. Only the bench's bus scenarios can show the remaining behaviour: that the right address is acknowledged and a wrong one is not, that bytes land in or leave the data register bit-exact, and that the filter lengths reject or pass glitches of a given width. They also show the acknowledge-send bit and the master's NACK taking effect, and the timeout firing at the programmed count and not before.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_RX, ST_TX} eng_st_t;
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_DATA = 3'd2;
  localparam logic [2:0] RA_OWN  = 3'd3;
  localparam logic [2:0] RA_TMO  = 3'd4;
endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
  parameter int LINES = 2,
  parameter int CW    = 2,
  parameter int SHORT = 2,
  parameter int LONG  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] filt
);
  logic [CW-1:0] lim;

  always_comb begin
    if (sel == 2'b01) lim = CW'(SHORT - 1);
    else              lim = CW'(LONG - 1);
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic          s1, s2, lvl, lvl_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
      lvl_nx = lvl;
      cnt_nx = '0;
      if (sel == 2'b00) begin
        lvl_nx = s2;
      end else if (s2 != lvl) begin
        if (cnt == lim) lvl_nx = s2;
        else            cnt_nx = cnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1  <= 1'b1;
        s2  <= 1'b1;
        lvl <= 1'b1;
        cnt <= '0;
      end else begin
        s1  <= raw[g];
        s2  <= s1;
        lvl <= lvl_nx;
        cnt <= cnt_nx;
      end
    end

    assign filt[g] = lvl;
  end
endmodule

// File: rtl/i2c_tgt_tmo.sv
module i2c_tgt_tmo #(
  parameter int SEL_W  = 6,
  parameter int UNIT_LG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             kick,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam int CNT_W = SEL_W + UNIT_LG;

  logic [CNT_W-1:0] cnt, cnt_nx, last;

  assign last = {sel, {UNIT_LG{1'b1}}};
  assign hit  = run && !kick && (cnt == last);

  always_comb begin
    if (!run || kick || hit) cnt_nx = '0;
    else                     cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/i2c_tgt_eng.sv
module i2c_tgt_eng
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          scl,
  input  logic          sda,
  input  logic [AW-1:0] own_addr,
  input  logic          ack_send,
  input  logic [DW-1:0] tx_byte,
  input  logic          tmo_hit,
  output logic          sda_oe,
  output logic          busy,
  output logic          addressed,
  output logic          rw,
  output logic          ack_rx,
  output logic          tx_mode,
  output logic          rx_load,
  output logic [DW-1:0] rx_byte,
  output logic          byte_done,
  output logic          addr_hit,
  output logic          scl_edge
);
  localparam int CNT_W = $clog2(DW + 2);
  localparam logic [CNT_W-1:0] LASTB = CNT_W'(DW);

  eng_st_t          st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [DW-1:0]    sh, sh_nx;
  logic             scl_q, sda_q, ackph, ackph_nx;
  logic             busy_nx, addr_nx, rw_nx, ack_rx_nx;
  logic             rise, fall, start, stop;

  assign rise  = scl && !scl_q;
  assign fall  = !scl && scl_q;
  assign start = scl && scl_q && sda_q && !sda;
  assign stop  = scl && scl_q && !sda_q && sda;
  assign scl_edge = rise || fall;
  assign rx_byte  = sh;
  assign tx_mode  = (st == ST_TX);

  assign sda_oe = en && ((st == ST_ADDR && ackph) ||
                         (st == ST_RX && ackph && !ack_send) ||
                         (st == ST_TX && !ackph && !sh[DW-1]));

  always_comb begin
    st_nx = st; cnt_nx = cnt; sh_nx = sh; ackph_nx = ackph;
    busy_nx = busy; addr_nx = addressed; rw_nx = rw; ack_rx_nx = ack_rx;
    rx_load = 1'b0; byte_done = 1'b0; addr_hit = 1'b0;
    if (!en || stop || tmo_hit) begin
      st_nx = ST_IDLE; cnt_nx = '0; ackph_nx = 1'b0;
      busy_nx = 1'b0; addr_nx = 1'b0;
    end else if (start) begin
      st_nx = ST_ADDR; cnt_nx = '0; ackph_nx = 1'b0;
      busy_nx = 1'b1; addr_nx = 1'b0;
    end else if (rise && st != ST_IDLE) begin
      cnt_nx = cnt + 1'b1;
      if (!ackph && (st == ST_ADDR || st == ST_RX)) sh_nx = {sh[DW-2:0], sda};
      if (ackph && st == ST_TX) ack_rx_nx = sda;
    end else if (fall && st != ST_IDLE) begin
      if (ackph) begin
        ackph_nx = 1'b0; cnt_nx = '0; byte_done = 1'b1;
        case (st)
          ST_ADDR: begin
            if (rw) begin st_nx = ST_TX; sh_nx = tx_byte; end
            else    st_nx = ST_RX;
          end
          ST_TX: begin
            if (ack_rx) st_nx = ST_IDLE;
            else        sh_nx = tx_byte;
          end
          default: ;
        endcase
      end else if (cnt == LASTB) begin
        case (st)
          ST_ADDR: begin
            if (sh[DW-1:1] == own_addr) begin
              ackph_nx = 1'b1; addr_nx = 1'b1; rw_nx = sh[0]; addr_hit = 1'b1;
            end else begin
              st_nx = ST_IDLE; cnt_nx = '0;
            end
          end
          ST_RX: begin ackph_nx = 1'b1; rx_load = 1'b1; end
          default: ackph_nx = 1'b1;
        endcase
      end else if (st == ST_TX && cnt != '0) begin
        sh_nx = {sh[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      st <= ST_IDLE; cnt <= '0; sh <= '0; ackph <= 1'b0;
      busy <= 1'b0; addressed <= 1'b0; rw <= 1'b0; ack_rx <= 1'b0;
    end else begin
      scl_q <= scl; sda_q <= sda;
      st <= st_nx; cnt <= cnt_nx; sh <= sh_nx; ackph <= ackph_nx;
      busy <= busy_nx; addressed <= addr_nx; rw <= rw_nx; ack_rx <= ack_rx_nx;
    end
  end
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter int AW     = 7,
  parameter int TSEL_W = 6,
  parameter int DEB_CW = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] reg_sel,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int DW = 8;

  logic rst_q1, rst_s;
  logic scl_f, sda_f;
  logic [1:0] deb_q, deb_nx;
  logic en_q, en_nx, acks_q, acks_nx, done_q, done_nx, wake_q, wake_nx;
  logic tmo_en_q, tmo_en_nx, tmo_flag_q, tmo_flag_nx;
  logic [TSEL_W-1:0] tmo_sel_q, tmo_sel_nx;
  logic [AW-1:0] own_q, own_nx;
  logic [DW-1:0] data_q, data_nx, rx_byte;
  logic busy, addressed, rw, ack_rx, tx_mode, rx_load, byte_done, addr_hit;
  logic scl_edge, tmo_hit, done_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_q1 <= 1'b0; rst_s <= 1'b0; end
    else        begin rst_q1 <= 1'b1; rst_s <= rst_q1; end
  end

  i2c_tgt_filt #(.LINES(2), .CW(DEB_CW)) u_filt (
    .clk(clk), .rst_n(rst_s), .sel(deb_q),
    .raw({scl_i, sda_i}), .filt({scl_f, sda_f})
  );

  i2c_tgt_tmo #(.SEL_W(TSEL_W)) u_tmo (
    .clk(clk), .rst_n(rst_s), .run(en_q && tmo_en_q && busy),
    .kick(scl_edge), .sel(tmo_sel_q), .hit(tmo_hit)
  );

  i2c_tgt_eng #(.AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_s), .en(en_q), .scl(scl_f), .sda(sda_f),
    .own_addr(own_q), .ack_send(acks_q), .tx_byte(data_q), .tmo_hit(tmo_hit),
    .sda_oe(sda_oe), .busy(busy), .addressed(addressed), .rw(rw),
    .ack_rx(ack_rx), .tx_mode(tx_mode), .rx_load(rx_load), .rx_byte(rx_byte),
    .byte_done(byte_done), .addr_hit(addr_hit), .scl_edge(scl_edge)
  );

  assign done_clr = reg_we && (reg_sel == RA_STAT) && !reg_wdata[7];

  always_comb begin
    deb_nx = deb_q; en_nx = en_q; own_nx = own_q; data_nx = data_q;
    acks_nx = acks_q; done_nx = done_q; wake_nx = wake_q;
    tmo_en_nx = tmo_en_q; tmo_sel_nx = tmo_sel_q; tmo_flag_nx = tmo_flag_q;
    if (reg_we) begin
      case (reg_sel)
        RA_CTRL: begin deb_nx = reg_wdata[3:2]; en_nx = reg_wdata[1]; end
        RA_STAT: begin
          acks_nx = reg_wdata[3];
          if (!reg_wdata[7]) done_nx = 1'b0;
          if (!reg_wdata[1]) wake_nx = 1'b0;
        end
        RA_DATA: data_nx = reg_wdata;
        RA_OWN:  own_nx = reg_wdata[7:1];
        RA_TMO: begin
          tmo_en_nx  = reg_wdata[7];
          tmo_sel_nx = reg_wdata[TSEL_W-1:0];
          if (!reg_wdata[6]) tmo_flag_nx = 1'b0;
        end
        default: ;
      endcase
    end
    if (rx_load)   data_nx = rx_byte;
    if (byte_done) done_nx = 1'b1;
    if (addr_hit)  wake_nx = 1'b1;
    if (tmo_hit)   tmo_flag_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      deb_q <= '0; en_q <= 1'b0; own_q <= '0; data_q <= '0;
      acks_q <= 1'b0; done_q <= 1'b0; wake_q <= 1'b0;
      tmo_en_q <= 1'b0; tmo_sel_q <= '0; tmo_flag_q <= 1'b0;
    end else begin
      deb_q <= deb_nx; en_q <= en_nx; own_q <= own_nx; data_q <= data_nx;
      acks_q <= acks_nx; done_q <= done_nx; wake_q <= wake_nx;
      tmo_en_q <= tmo_en_nx; tmo_sel_q <= tmo_sel_nx; tmo_flag_q <= tmo_flag_nx;
    end
  end

  always_comb begin
    case (reg_sel)
      RA_CTRL: reg_rdata = {4'b0, deb_q, en_q, 1'b0};
      RA_STAT: reg_rdata = {done_q, addressed, busy, tx_mode, acks_q, rw, wake_q, ack_rx};
      RA_DATA: reg_rdata = data_q;
      RA_OWN:  reg_rdata = {own_q, 1'b0};
      RA_TMO:  reg_rdata = {tmo_en_q, tmo_flag_q, tmo_sel_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic sda_oe,
  input logic scl_f,
  input logic busy,
  input logic addressed,
  input logic done,
  input logic done_clr,
  input logic tmo_flag
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !sda_oe); // R10
  AST_ADDR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) addressed |-> busy); // R8
  AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !addressed); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (done && !done_clr) |=> done); // R7
  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_f); // R6
  AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tmo_flag) |-> !busy); // R9
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
  .clk(clk), .rst_n(rst_s), .en(en_q), .sda_oe(sda_oe), .scl_f(scl_f),
  .busy(busy), .addressed(addressed), .done(done_q), .done_clr(done_clr),
  .tmo_flag(tmo_flag_q)
);

// File: tb/sim_i2c_tgt.sv
module sim_i2c_tgt;
  localparam int Q = 20;
  localparam logic [7:0] OWN = 8'hB4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl_m, sda_m, reg_we, sda_oe;
  logic [2:0] reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] rxq[$];

  i2c_tgt u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_sel = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_sel = a; #1; d = reg_rdata;
  endtask

  task automatic m_start();
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic m_bit(input logic b, input int glitch, output logic r);
    sda_m = b; wclk(Q); scl_m = 1'b1; wclk(Q/2);
    if (glitch > 0) begin scl_m = 1'b0; wclk(glitch); scl_m = 1'b1; end
    wclk(Q/2); r = sda_line; scl_m = 1'b0; wclk(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] v, input int glen, output logic ack);
    logic r;
    for (int i = 0; i < 8; i++) m_bit(v[7-i], (i == 0) ? glen : 0, r);
    m_bit(1'b1, 0, ack);
  endtask

  task automatic m_rbyte(output logic [7:0] v);
    logic r;
    for (int i = 0; i < 8; i++) begin m_bit(1'b1, 0, r); v[7-i] = r; end
  endtask

  task automatic deb_case(input logic [7:0] ctrl, input int glen, input logic exp_ack, input string tag);
    logic a;
    wr(3'd0, ctrl);
    m_start();
    m_wbyte(OWN, glen, a);
    chk(tag, a, exp_ack);
    m_stop();
  endtask

  initial begin
    logic [7:0] d;
    logic a;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    wclk(3); rst_n = 1'b1; wclk(4);

    // R1: reset state
    for (int i = 0; i < 5; i++) begin rd(3'(i), d); chk("R1 reg reset", d, 8'h00); end
    chk("R1 sda_oe reset", sda_oe, 1'b0);

    // R11: register map and read-back masks
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R11 ctrl mask", d, 8'h0E);
    wr(3'd3, 8'hB5); rd(3'd3, d); chk("R11 own mask", d, 8'hB4);
    wr(3'd0, 8'h00);

    // R10: disabled target ignores the bus
    m_start(); rd(3'd1, d); chk("R10 busy while disabled", d[5], 1'b0);
    m_wbyte(OWN, 0, a); chk("R10 no ack while disabled", a, 1'b1);
    m_stop();

    // R3 R4 R5 R7 receive path
    wr(3'd0, 8'h02);
    m_start(); rd(3'd1, d); chk("R3 busy after START", d[5], 1'b1);
    m_wbyte(OWN, 0, a); chk("R4 address ack", a, 1'b0);
    rd(3'd1, d);
    chk("R4 addressed flag", d[6], 1'b1);
    chk("R4 match flag", d[1], 1'b1);
    chk("R4 rw latched write", d[2], 1'b0);
    chk("R7 done after address", d[7], 1'b1);
    wr(3'd1, 8'h00); rd(3'd1, d); chk("R7 done cleared", d[7], 1'b0);
    rxq.push_back(8'h96);
    m_wbyte(8'h96, 0, a); chk("R5 ack when send bit 0", a, 1'b0);
    rd(3'd2, d); chk("R5 rx byte", d, rxq.pop_front());
    wr(3'd1, 8'h08);
    rxq.push_back(8'h41);
    m_wbyte(8'h41, 0, a); chk("R5 nack when send bit 1", a, 1'b1);
    rd(3'd2, d); chk("R5 rx byte 2", d, rxq.pop_front());
    rd(3'd1, d); chk("R7 done after data byte", d[7], 1'b1);
    m_start(); rd(3'd1, d);
    chk("R8 repeated START clears addressed", d[6], 1'b0);
    chk("R3 busy on repeated START", d[5], 1'b1);
    m_wbyte(8'h66, 0, a); chk("R4 wrong address nack", a, 1'b1);
    rd(3'd1, d); chk("R4 no addressed on mismatch", d[6], 1'b0);
    m_stop(); rd(3'd1, d); chk("R3 busy cleared by STOP", d[5], 1'b0);

    // R6 transmit path
    wr(3'd1, 8'h00); wr(3'd2, 8'hA5);
    m_start(); m_wbyte(OWN | 8'h01, 0, a); chk("R4 read address ack", a, 1'b0);
    rd(3'd1, d); chk("R4 rw latched read", d[2], 1'b1); chk("R6 transmit mode", d[4], 1'b1);
    m_rbyte(d); chk("R6 first tx byte", d, 8'hA5);
    wr(3'd2, 8'h3C);
    m_bit(1'b0, 0, a);
    rd(3'd1, d); chk("R6 master ack stored", d[0], 1'b0); chk("R7 done after tx byte", d[7], 1'b1);
    m_rbyte(d); chk("R6 second tx byte", d, 8'h3C);
    m_bit(1'b1, 0, a); chk("R6 SDA released on 9th clock", a, 1'b1);
    rd(3'd1, d); chk("R6 master nack stored", d[0], 1'b1); chk("R6 tx ends after nack", d[4], 1'b0);
    m_stop(); rd(3'd1, d); chk("R8 addressed cleared by STOP", d[6], 1'b0);

    // R2 input filter lengths
    deb_case(8'h0A, 3, 1'b0, "R2 4-clock filter rejects 3-clock glitch");
    deb_case(8'h0E, 3, 1'b0, "R2 select 11 acts as 4 clocks");
    deb_case(8'h06, 3, 1'b1, "R2 2-clock filter passes 3-clock glitch");
    deb_case(8'h06, 1, 1'b0, "R2 2-clock filter rejects 1-clock glitch");
    deb_case(8'h02, 1, 1'b1, "R2 no filter passes 1-clock glitch");

    // R9 bus timeout
    wr(3'd4, 8'h80);
    m_start(); wclk(30);
    rd(3'd4, d); chk("R9 no timeout before 64", d[6], 1'b0);
    rd(3'd1, d); chk("R9 busy before timeout", d[5], 1'b1);
    wclk(40);
    rd(3'd4, d); chk("R9 timeout flag at 64", d, 8'hC0);
    rd(3'd1, d); chk("R9 busy cleared by timeout", d[5], 1'b0);
    wr(3'd4, 8'h81); rd(3'd4, d); chk("R9 flag cleared by write", d, 8'h81);
    m_start(); wclk(100);
    rd(3'd4, d); chk("R9 no timeout before 128", d[6], 1'b0);
    wclk(60);
    rd(3'd4, d); chk("R9 timeout flag at 128", d[6], 1'b1);
    m_stop(); wr(3'd4, 8'h00);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wclk(150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule